// File: doc/BRIEF.md
# Four-Channel Register-Controlled PWM Generator

This block produces four independent pulse-width-modulated outputs from one system clock. Each channel owns one 32-bit control word in a small memory-mapped register file. The word holds a run bit, an 8-bit high-time value and a 13-bit clock divider. Software writes the words over a simple synchronous bus with address, write strobe and write data. The bus reads back through a combinational data port.

Each running channel divides the system clock by its divider value plus one. It counts divided ticks in an 8-bit counter that wraps every 256 ticks, and it holds its output high while that counter is below the high-time value. Divider and high-time changes made while a channel runs are held in a per-channel staging copy and applied only when the counter wraps, so a period never mixes old and new settings. Converting times into register values is left to software.

Top module: `pwm_quad`

## Requirements
- R1: There are four channels. Channel c (0 to 3) is controlled by the word at byte address c*16 (0x00, 0x10, 0x20, 0x30). After reset every control word reads 0x00000000 and every output is low.
- R2: In a control word, bit 31 is the run bit, bits 23:16 the high-time value and bits 12:0 the divider. These read back exactly as written, and all other bits read as zero (writing 0xFFFFFFFF reads back 0x80FF1FFF).
- R3: A read of any address that is not a multiple of 16 returns zero. A write to such an address changes no control word.
- R4: A running channel with divider S advances its period counter once every S+1 clock cycles, and one output period lasts 256*(S+1) cycles. This holds up to the largest divider, 8191.
- R5: The output is high while the period counter is below the high-time value D: high-time 0 keeps the output low, and 255 gives 255 high ticks out of 256.
- R6: A channel whose run bit is clear drives its output low and holds its counters at zero. Writing 0x00000000 to a channel stops it and clears its settings.
- R7: After the edge that sets the run bit, the counters start from zero. With S and D, the output sampled i cycles after that edge is high exactly when floor(i/(S+1)) mod 256 < D.
- R8: High-time and divider values written while a channel runs take effect only at the next period boundary.
- R9: Clearing or setting the run bit by read-modify-write leaves the high-time and divider fields unchanged.
- R10: The channels run independently: settings, start time and output of one channel do not affect another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 6 | Byte address of the control word |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The hardest case to reach from the ports is a settings update that arrives in the middle of a running period. The bench has to show that the old high-time still governs the rest of that period and that the new high-time and divider take over at exactly the wrap. To do this, the bench starts a channel with a known divider and high-time and lets a counted number of cycles pass. It then rewrites the word with the run bit still set. After that it compares every cycle against a model that switches settings only at 256*(S+1) cycles after the start. The largest divider is reached by running a channel with divider 8191 and high-time 1 for just over one tick of the period counter.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  localparam int NCH       = 4;
  localparam int STRIDE_LG = 4;
  localparam int AW        = $clog2(NCH) + STRIDE_LG;
  localparam int DUTY_W    = 8;
  localparam int SCALE_W   = 13;
  localparam int RUN_BIT   = 31;
  localparam int DUTY_LSB  = 16;
  localparam int SCALE_LSB = 0;

  typedef struct packed {
    logic              run;
    logic [DUTY_W-1:0] duty;
    logic [SCALE_W-1:0] scale;
  } chan_cfg_t;

  function automatic logic [31:0] cfg_to_word(chan_cfg_t c);
    logic [31:0] w;
    w = '0;
    w[RUN_BIT] = c.run;
    w[DUTY_LSB +: DUTY_W] = c.duty;
    w[SCALE_LSB +: SCALE_W] = c.scale;
    return w;
  endfunction

  function automatic chan_cfg_t word_to_cfg(logic [31:0] w);
    chan_cfg_t c;
    c.run = w[RUN_BIT];
    c.duty = w[DUTY_LSB +: DUTY_W];
    c.scale = w[SCALE_LSB +: SCALE_W];
    return c;
  endfunction
endpackage

// File: rtl/pwmq_regs.sv
module pwmq_regs
  import pwmq_pkg::*;
#(
  parameter int N_CH = NCH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output chan_cfg_t       cfg_o [N_CH]
);
  localparam logic [31:0] LIVE_MASK = cfg_to_word('1);

  chan_cfg_t       cfg_q [N_CH];
  chan_cfg_t       cfg_d [N_CH];
  logic [N_CH-1:0] wr_hit;
  logic            unused_wbits;

  assign unused_wbits = ^(wdata & ~LIVE_MASK);

  // write decode: only exact word addresses are mapped
  always_comb begin
    for (int c = 0; c < N_CH; c++) begin
      wr_hit[c] = wr && (addr == AW'(c << STRIDE_LG));
    end
  end

  always_comb begin
    for (int c = 0; c < N_CH; c++) begin
      cfg_d[c] = wr_hit[c] ? word_to_cfg(wdata) : cfg_q[c];
    end
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (addr == AW'(c << STRIDE_LG)) rdata = cfg_to_word(cfg_q[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < N_CH; c++) cfg_q[c] <= '0;
    end else begin
      for (int c = 0; c < N_CH; c++) cfg_q[c] <= cfg_d[c];
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pwmq_chan.sv
module pwmq_chan
  import pwmq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cfg_t         cfg_i,
  output logic              pwm_o,
  output logic [DUTY_W-1:0] per_cnt_o,
  output logic [DUTY_W-1:0] duty_act_o
);
  logic               run_q, run_d;
  logic [SCALE_W-1:0] pre_q, pre_d;
  logic [DUTY_W-1:0]  per_q, per_d;
  logic [DUTY_W-1:0]  shd_duty_q, shd_duty_d;
  logic [SCALE_W-1:0] shd_scale_q, shd_scale_d;
  logic [DUTY_W-1:0]  duty_act;
  logic [SCALE_W-1:0] scale_act;
  logic               tick, wrap, shd_load;

  always_comb begin
    // first running cycle uses the live word, later ones the staged copy
    duty_act  = run_q ? shd_duty_q  : cfg_i.duty;
    scale_act = run_q ? shd_scale_q : cfg_i.scale;
    tick      = (pre_q == scale_act);
    wrap      = tick && (per_q == '1);
    run_d     = cfg_i.run;

    if (!cfg_i.run) begin
      pre_d = '0;
      per_d = '0;
    end else begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      per_d = tick ? per_q + 1'b1 : per_q;
    end

    shd_load    = !run_q || wrap;
    shd_duty_d  = shd_load ? cfg_i.duty  : shd_duty_q;
    shd_scale_d = shd_load ? cfg_i.scale : shd_scale_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      pre_q       <= '0;
      per_q       <= '0;
      shd_duty_q  <= '0;
      shd_scale_q <= '0;
    end else begin
      run_q       <= run_d;
      pre_q       <= pre_d;
      per_q       <= per_d;
      shd_duty_q  <= shd_duty_d;
      shd_scale_q <= shd_scale_d;
    end
  end

  assign pwm_o      = cfg_i.run && (per_q < duty_act);
  assign per_cnt_o  = per_q;
  assign duty_act_o = duty_act;
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwmq_pkg::*;
#(
  parameter int N_CH = NCH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [N_CH-1:0] pwm_out
);
  logic [1:0]             rst_sync_q;
  logic                   rst_sync_n;
  chan_cfg_t              cfg [N_CH];
  logic [N_CH-1:0]        ch_en;
  logic [N_CH*DUTY_W-1:0] per_flat;
  logic [N_CH*DUTY_W-1:0] duty_flat;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pwmq_regs #(.N_CH(N_CH)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .addr  (bus_addr),
    .wr    (bus_wr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .cfg_o (cfg)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pwmq_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .cfg_i      (cfg[g]),
      .pwm_o      (pwm_out[g]),
      .per_cnt_o  (per_flat[g*DUTY_W +: DUTY_W]),
      .duty_act_o (duty_flat[g*DUTY_W +: DUTY_W])
    );
    assign ch_en[g] = cfg[g].run;
  end
endmodule

// File: rtl/pwmq_checker.sv
module pwmq_checker
  import pwmq_pkg::*;
#(
  parameter int N_CH = NCH
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [AW-1:0]          bus_addr,
  input logic [31:0]            bus_rdata,
  input logic [N_CH-1:0]        pwm_out,
  input logic [N_CH-1:0]        ch_en,
  input logic [N_CH*DUTY_W-1:0] per_flat,
  input logic [N_CH*DUTY_W-1:0] duty_flat
);
  logic unused_addr_hi;
  assign unused_addr_hi = ^bus_addr[AW-1:STRIDE_LG];

  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[STRIDE_LG-1:0] != '0) |-> (bus_rdata == 32'h0));

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_out[g] |-> ch_en[g]);

    assert_off_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[g] |=> (per_flat[g*DUTY_W +: DUTY_W] == '0));

    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[g] && $past(ch_en[g])) |->
        ((per_flat[g*DUTY_W +: DUTY_W] == $past(per_flat[g*DUTY_W +: DUTY_W])) ||
         (per_flat[g*DUTY_W +: DUTY_W] == $past(per_flat[g*DUTY_W +: DUTY_W]) + 8'd1)));

    assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_flat[g*DUTY_W +: DUTY_W] == '0) |-> !pwm_out[g]);

    assert_duty_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[g] && $past(ch_en[g]) && $past(ch_en[g], 2) &&
       (per_flat[g*DUTY_W +: DUTY_W] != '0)) |->
        $stable(duty_flat[g*DUTY_W +: DUTY_W]));
  end
endmodule

bind pwm_quad pwmq_checker #(.N_CH(N_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pwm_out   (pwm_out),
  .ch_en     (ch_en),
  .per_flat  (per_flat),
  .duty_flat (duty_flat)
);

// File: tb/sim_pwm_quad.sv
`timescale 1ns/1ps
module sim_pwm_quad;
  import pwmq_pkg::*;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [3:0]    pwm;

  int nchk = 0;
  int nfail = 0;
  int ncyc = 0;

  // per-channel model: start cycle, first-period and later settings
  bit en_m [4];
  int st_m [4];
  int s0_m [4];
  int d0_m [4];
  int s1_m [4];
  int d1_m [4];

  always #2.5 clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  pwm_quad u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm)
  );

  function automatic logic [31:0] mk(bit r, int d, int s);
    return {r, 7'b0, 8'(d), 3'b0, 13'(s)};
  endfunction

  function automatic bit exp_out(int ch);
    int i, p0, j;
    if (!en_m[ch]) return 1'b0;
    i = ncyc - st_m[ch];
    p0 = 256 * (s0_m[ch] + 1);
    if (i < p0) return (i / (s0_m[ch] + 1)) < d0_m[ch];
    j = i - p0;
    return ((j / (s1_m[ch] + 1)) % 256) < d1_m[ch];
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(int a, logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(int a, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  task automatic start_ch(int ch, int s, int d);
    bus_write(ch * 16, mk(1'b1, d, s));
    en_m[ch] = 1'b1; st_m[ch] = ncyc;
    s0_m[ch] = s; d0_m[ch] = d; s1_m[ch] = s; d1_m[ch] = d;
  endtask

  task automatic stop_ch(int ch);
    bus_write(ch * 16, 32'h0);
    en_m[ch] = 1'b0;
  endtask

  // compares all outputs against the model for n cycles
  task automatic watch(int n, string tag);
    int bad = 0;
    logic [3:0] first_act = '0, first_exp = '0;
    for (int k = 0; k < n; k++) begin
      logic [3:0] e;
      for (int c = 0; c < 4; c++) e[c] = exp_out(c);
      if (pwm !== e) begin
        if (bad == 0) begin first_act = pwm; first_exp = e; end
        bad++;
      end
      @(negedge clk);
    end
    check(bad == 0, tag, first_act, first_exp);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int c = 0; c < 4; c++) begin
      bus_read(c * 16, v);
      check(v == 32'h0, "R1 reset word", v, 0);
    end
    check(pwm == 4'h0, "R1 reset outputs low", pwm, 0);
  endtask

  task automatic t_fields;
    logic [31:0] v;
    bus_write(32, 32'hFFFF_FFFF);
    bus_read(32, v);
    check(v == 32'h80FF_1FFF, "R2 field readback", v, 32'h80FF1FFF);
    bus_write(32, 32'h0);
    bus_read(32, v);
    check(v == 32'h0, "R6 zero write clears word", v, 0);
    check(pwm == 4'h0, "R6 zero write output low", pwm, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    bus_write(0, 32'h0007_0002);
    bus_write(4, 32'hFFFF_FFFF);
    bus_write(8'h3C, 32'hFFFF_FFFF);
    bus_read(4, v);
    check(v == 32'h0, "R3 unmapped read zero", v, 0);
    bus_read(0, v);
    check(v == 32'h0007_0002, "R3 unmapped write ignored ch0", v, 32'h00070002);
    bus_read(48, v);
    check(v == 32'h0, "R3 unmapped write ignored ch3", v, 0);
    check(pwm == 4'h0, "R3 unmapped write no output", pwm, 0);
    bus_write(0, 32'h0);
  endtask

  task automatic t_basic;
    start_ch(0, 0, 64);
    watch(600, "R7 R5 undivided duty 64");
    stop_ch(0);
  endtask

  task automatic t_presc;
    start_ch(1, 3, 100);
    watch(1100, "R4 divider 3 duty 100");
    stop_ch(1);
  endtask

  task automatic t_extremes;
    start_ch(2, 1, 0);
    start_ch(3, 0, 255);
    watch(800, "R5 duty 0 and 255");
    stop_ch(2);
    stop_ch(3);
  endtask

  task automatic t_multi;
    start_ch(0, 2, 17);
    start_ch(1, 0, 200);
    start_ch(2, 5, 128);
    start_ch(3, 1, 3);
    watch(2000, "R10 four channels independent");
    for (int c = 0; c < 4; c++) stop_ch(c);
    @(negedge clk);
    check(pwm == 4'h0, "R6 all stopped low", pwm, 0);
  endtask

  task automatic t_boundary;
    start_ch(0, 1, 200);
    watch(100, "R8 before update");
    bus_write(0, mk(1'b1, 30, 0));
    s1_m[0] = 0; d1_m[0] = 30;
    watch(700, "R8 update at period boundary");
    stop_ch(0);
  endtask

  task automatic t_rmw;
    logic [31:0] v;
    start_ch(1, 2, 90);
    watch(300, "R9 running before clear");
    bus_read(16, v);
    bus_write(16, v & ~32'h8000_0000);
    en_m[1] = 1'b0;
    check(pwm[1] == 1'b0, "R6 cleared run bit output low", pwm[1], 0);
    bus_read(16, v);
    check(v == 32'h005A_0002, "R9 fields kept after clear", v, 32'h005A0002);
    watch(50, "R6 stopped stays low");
    bus_read(16, v);
    bus_write(16, v | 32'h8000_0000);
    en_m[1] = 1'b1; st_m[1] = ncyc;
    watch(900, "R7 R9 restart from zero");
    bus_read(16, v);
    check(v == 32'h805A_0002, "R9 fields kept after set", v, 32'h805A0002);
    stop_ch(1);
  endtask

  task automatic t_maxscale;
    start_ch(3, 8191, 1);
    watch(8300, "R4 largest divider");
    stop_ch(3);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin
      en_m[c] = 0; st_m[c] = 0; s0_m[c] = 0; d0_m[c] = 0; s1_m[c] = 0; d1_m[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fields();
    t_unmapped();
    t_basic();
    t_presc();
    t_extremes();
    t_multi();
    t_boundary();
    t_rmw();
    t_maxscale();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule